// File: doc/BRIEF.md
# Clock-Tile Reconfiguration Port Bridge

This block sits on a simple register bus and gives a host a path into the dynamic reconfiguration port (DRP) of a clock-management tile. Four registers are decoded. A reset register releases the block and enables the tile. A source register picks one of two input clocks for the tile. A command register starts a single DRP access. A status register reports whether an access is still in flight and holds the data returned by the last read.

The host writes one command word that carries all of the access at once: a start flag, a read flag, a 7-bit DRP address and 16 bits of write data. The bridge issues a one-cycle enable on the DRP with write-enable set for writes. It keeps the address and data steady and holds a busy flag until the tile returns its ready strobe. Software then polls the status word until busy clears, and on a read takes the returned data from the same word.

The register bus uses one-cycle strobes. Writes take effect at the clock edge that samples the strobe. Read data appears combinationally while the read strobe is high.

Top module: `drp_reg_bridge`

## Requirements
- R1: After reset, `blk_en`, `tile_en`, `src_sel`, `drp_en` and `drp_we` are 0, and the status word (offset 0x74) reads 0.
- R2: A write to offset 0x40 loads bit 0 into `blk_en` and bit 1 into `tile_en` at the sampling edge. A read of 0x40 returns those two bits in positions 1:0 and zero above them.
- R3: A write to offset 0x44 loads bit 0 into `src_sel`. A read of 0x44 returns that bit in position 0, and every higher bit of the write is dropped.
- R4: A write to offset 0x70 with bit 29 set, while idle, raises `drp_en` for exactly one cycle, starting the cycle after the write. During that cycle `drp_we` is the inverse of bit 28, `drp_addr` is bits 22:16 and `drp_di` is bits 15:0.
- R5: Status bit 16 (busy) is 1 from the cycle after the start write until the edge that samples `drp_rdy`. It is 0 from the next cycle on. With the tile answering L cycles after the enable cycle, busy reads 1 for exactly L+2 consecutive cycles.
- R6: On a read access (bit 28 = 1), `drp_do` is captured into status bits 15:0 at the ready edge. A write access leaves status bits 15:0 unchanged.
- R7: A command write arriving while busy starts nothing and alters neither the DRP outputs nor the command readback. A command write with bit 29 clear starts nothing.
- R8: A `drp_rdy` pulse while idle changes neither busy nor status bits 15:0.
- R9: Reads of any offset other than 0x40, 0x44, 0x70 and 0x74 return 0, and `reg_rdata` is 0 whenever `reg_rd` is low.
- R10: A read of 0x70 returns the last accepted command word with bit 29 forced to 0.
- R11: `drp_addr`, `drp_di` and `drp_we` stay unchanged while an access is in flight, apart from `drp_we` dropping after the enable cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while `reg_rd` is high |
| blk_en | output | 1 | General reset release / block enable |
| tile_en | output | 1 | Clock-tile enable |
| src_sel | output | 1 | Input clock index for the tile |
| drp_en | output | 1 | DRP access enable, one-cycle pulse |
| drp_we | output | 1 | DRP write enable, valid with `drp_en` |
| drp_addr | output | 7 | DRP register address |
| drp_di | output | 16 | DRP write data |
| drp_do | input | 16 | DRP read data, valid with `drp_rdy` |
| drp_rdy | input | 1 | DRP access-complete strobe |

## Verification
Configuration registers and the command capture settle at the edge that samples the write strobe. The bench therefore checks `blk_en`, `tile_en`, `src_sel`, `drp_en` and the DRP fields at the falling edge that follows that edge. Busy is expected for exactly L+2 falling edges after a start, where a behavioural tile answers L cycles after the enable. Captured read data is due one edge after `drp_rdy`, so it is checked once busy has dropped. All bus inputs change on falling edges. Read data is combinational and is sampled a fraction of a cycle after the strobe goes up.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_RESET  = 8'h40;
    localparam logic [7:0] OFS_SOURCE = 8'h44;
    localparam logic [7:0] OFS_CMD    = 8'h70;
    localparam logic [7:0] OFS_STATUS = 8'h74;

    // Command word field positions
    localparam int unsigned CMD_START_BIT = 29;
    localparam int unsigned CMD_READ_BIT  = 28;
    localparam int unsigned CMD_ADDR_LSB  = 16;

    // Status word field positions
    localparam int unsigned STS_BUSY_BIT  = 16;

    // Reset register field positions
    localparam int unsigned RST_BLK_BIT   = 0;
    localparam int unsigned RST_TILE_BIT  = 1;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_ISSUE = 2'd1,
        XF_WAIT  = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/drp_cfg_regs.sv
module drp_cfg_regs #(
    parameter int unsigned SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_reset,
    input  logic             wr_source,
    input  logic [1:0]       reset_bits,
    input  logic [SEL_W-1:0] source_bits,
    output logic             blk_en,
    output logic             tile_en,
    output logic [SEL_W-1:0] src_sel
);

    typedef struct packed {
        logic             blk;
        logic             tile;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_reset) begin
            cfg_d.blk  = reset_bits[0];
            cfg_d.tile = reset_bits[1];
        end
        if (wr_source) begin
            cfg_d.sel = source_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign blk_en  = cfg_q.blk;
    assign tile_en = cfg_q.tile;
    assign src_sel = cfg_q.sel;

endmodule

// File: rtl/drp_xfer_fsm.sv
module drp_xfer_fsm
    import drp_bridge_pkg::*;
#(
    parameter int unsigned BUS_DW = 32,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [BUS_DW-1:0] cmd_word,
    input  logic              drp_rdy,
    input  logic [DRP_DW-1:0] drp_do,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    output logic              busy,
    output logic [DRP_DW-1:0] rd_data,
    output logic [BUS_DW-1:0] cmd_echo
);

    typedef struct packed {
        xfer_state_e       st;
        logic [BUS_DW-1:0] cmd;
        logic [DRP_DW-1:0] rdat;
    } xfer_t;

    xfer_t x_d, x_q;
    logic  start_req;

    assign start_req = cmd_wr && cmd_word[CMD_START_BIT];

    always_comb begin
        x_d = x_q;
        unique case (x_q.st)
            XF_IDLE: begin
                if (start_req) begin
                    x_d.st  = XF_ISSUE;
                    x_d.cmd = cmd_word;
                end
            end
            XF_ISSUE, XF_WAIT: begin
                if (drp_rdy) begin
                    x_d.st = XF_IDLE;
                    if (x_q.cmd[CMD_READ_BIT]) begin
                        x_d.rdat = drp_do;
                    end
                end else begin
                    x_d.st = XF_WAIT;
                end
            end
            default: begin
                x_d.st = XF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '{st: XF_IDLE, cmd: '0, rdat: '0};
        end else begin
            x_q <= x_d;
        end
    end

    always_comb begin
        cmd_echo                = x_q.cmd;
        cmd_echo[CMD_START_BIT] = 1'b0;
    end

    assign drp_en   = (x_q.st == XF_ISSUE);
    assign drp_we   = drp_en && !x_q.cmd[CMD_READ_BIT];
    assign drp_addr = x_q.cmd[CMD_ADDR_LSB +: DRP_AW];
    assign drp_di   = x_q.cmd[DRP_DW-1:0];
    assign busy     = (x_q.st != XF_IDLE);
    assign rd_data  = x_q.rdat;

endmodule

// File: rtl/drp_rd_mux.sv
module drp_rd_mux
    import drp_bridge_pkg::*;
#(
    parameter int unsigned BUS_AW = 8,
    parameter int unsigned BUS_DW = 32,
    parameter int unsigned DRP_DW = 16,
    parameter int unsigned SEL_W  = 1
) (
    input  logic              rd,
    input  logic [BUS_AW-1:0] addr,
    input  logic              blk_en,
    input  logic              tile_en,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [BUS_DW-1:0] cmd_echo,
    input  logic              busy,
    input  logic [DRP_DW-1:0] rd_data,
    output logic [BUS_DW-1:0] rdata
);

    logic [BUS_DW-1:0] sel_d;

    always_comb begin
        sel_d = '0;
        unique case (addr)
            BUS_AW'(OFS_RESET): begin
                sel_d[RST_BLK_BIT]  = blk_en;
                sel_d[RST_TILE_BIT] = tile_en;
            end
            BUS_AW'(OFS_SOURCE): begin
                sel_d[SEL_W-1:0] = src_sel;
            end
            BUS_AW'(OFS_CMD): begin
                sel_d = cmd_echo;
            end
            BUS_AW'(OFS_STATUS): begin
                sel_d[STS_BUSY_BIT] = busy;
                sel_d[DRP_DW-1:0]   = rd_data;
            end
            default: begin
                sel_d = '0;
            end
        endcase
        rdata = rd ? sel_d : '0;
    end

endmodule

// File: rtl/drp_reg_bridge.sv
module drp_reg_bridge
    import drp_bridge_pkg::*;
#(
    parameter int unsigned BUS_AW = 8,
    parameter int unsigned BUS_DW = 32,
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16,
    parameter int unsigned SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [BUS_DW-1:0] reg_wdata,
    output logic [BUS_DW-1:0] reg_rdata,
    output logic              blk_en,
    output logic              tile_en,
    output logic [SEL_W-1:0]  src_sel,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_di,
    input  logic [DRP_DW-1:0] drp_do,
    input  logic              drp_rdy
);

    logic              wr_reset, wr_source, wr_cmd;
    logic              xfer_busy;
    logic [DRP_DW-1:0] xfer_rd_data;
    logic [BUS_DW-1:0] cmd_echo;

    assign wr_reset  = reg_wr && (reg_addr == BUS_AW'(OFS_RESET));
    assign wr_source = reg_wr && (reg_addr == BUS_AW'(OFS_SOURCE));
    assign wr_cmd    = reg_wr && (reg_addr == BUS_AW'(OFS_CMD));

    drp_cfg_regs #(
        .SEL_W (SEL_W)
    ) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_reset    (wr_reset),
        .wr_source   (wr_source),
        .reset_bits  (reg_wdata[1:0]),
        .source_bits (reg_wdata[SEL_W-1:0]),
        .blk_en      (blk_en),
        .tile_en     (tile_en),
        .src_sel     (src_sel)
    );

    drp_xfer_fsm #(
        .BUS_DW (BUS_DW),
        .DRP_AW (DRP_AW),
        .DRP_DW (DRP_DW)
    ) i_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_cmd),
        .cmd_word (reg_wdata),
        .drp_rdy  (drp_rdy),
        .drp_do   (drp_do),
        .drp_en   (drp_en),
        .drp_we   (drp_we),
        .drp_addr (drp_addr),
        .drp_di   (drp_di),
        .busy     (xfer_busy),
        .rd_data  (xfer_rd_data),
        .cmd_echo (cmd_echo)
    );

    drp_rd_mux #(
        .BUS_AW (BUS_AW),
        .BUS_DW (BUS_DW),
        .DRP_DW (DRP_DW),
        .SEL_W  (SEL_W)
    ) i_rmux (
        .rd       (reg_rd),
        .addr     (reg_addr),
        .blk_en   (blk_en),
        .tile_en  (tile_en),
        .src_sel  (src_sel),
        .cmd_echo (cmd_echo),
        .busy     (xfer_busy),
        .rd_data  (xfer_rd_data),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/drp_bridge_checker.sv
module drp_bridge_checker #(
    parameter int unsigned DRP_AW = 7,
    parameter int unsigned DRP_DW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drp_en,
    input logic              drp_we,
    input logic              drp_rdy,
    input logic [DRP_AW-1:0] drp_addr,
    input logic [DRP_DW-1:0] drp_di,
    input logic              xfer_busy,
    input logic [DRP_DW-1:0] xfer_rd_data
);

    // R4: enable is a single-cycle pulse
    p_en_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);

    // R4: write enable only with the enable pulse
    p_we_with_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we |-> drp_en);

    // R5: an issued access is always accounted as busy
    p_en_means_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> xfer_busy);

    // R5: busy holds until the ready strobe
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !drp_rdy) |=> xfer_busy);

    // R5: ready ends the access on the next cycle
    p_busy_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && drp_rdy) |=> !xfer_busy);

    // R7: no new enable pulse can come out of a busy cycle
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> !drp_en);

    // R8: captured data only moves during an access
    p_idle_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |=> $stable(xfer_rd_data));

    // R11: address and write data held across the access
    p_fields_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> ($stable(drp_addr) && $stable(drp_di)));

endmodule

bind drp_reg_bridge drp_bridge_checker #(
    .DRP_AW (DRP_AW),
    .DRP_DW (DRP_DW)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drp_en       (drp_en),
    .drp_we       (drp_we),
    .drp_rdy      (drp_rdy),
    .drp_addr     (drp_addr),
    .drp_di       (drp_di),
    .xfer_busy    (xfer_busy),
    .xfer_rd_data (xfer_rd_data)
);

// File: tb/test_drp_reg_bridge.sv
`timescale 1ns/1ps
module test_drp_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        blk_en, tile_en;
    logic [0:0]  src_sel;
    logic        drp_en, drp_we;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do;
    logic        drp_rdy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    drp_reg_bridge i_drp_reg_bridge (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .blk_en(blk_en), .tile_en(tile_en), .src_sel(src_sel),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
        .drp_di(drp_di), .drp_do(drp_do), .drp_rdy(drp_rdy)
    );

    // Behavioural tile responder
    logic [15:0] tile_mem [128];
    int          resp_lat = 1;
    int          p_cnt = 0;
    logic [6:0]  p_addr = '0;
    logic        p_we = 1'b0;
    logic [15:0] p_di = '0;
    logic        resp_rdy = 1'b0;
    logic [15:0] resp_do = 16'hDEAD;
    logic        force_rdy = 1'b0;

    assign drp_rdy = resp_rdy | force_rdy;
    assign drp_do  = resp_do;

    initial begin
        for (int i = 0; i < 128; i++) tile_mem[i] = 16'(i) ^ 16'hA500;
    end

    always @(posedge clk) begin
        resp_rdy <= 1'b0;
        resp_do  <= 16'hDEAD;
        if (drp_en) begin
            p_cnt  <= resp_lat;
            p_addr <= drp_addr;
            p_we   <= drp_we;
            p_di   <= drp_di;
        end else if (p_cnt != 0) begin
            p_cnt <= p_cnt - 1;
            if (p_cnt == 1) begin
                resp_rdy <= 1'b1;
                if (p_we) tile_mem[p_addr] <= p_di;
                else      resp_do <= tile_mem[p_addr];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #0.5;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    // Counts falling edges with busy high, starting at the current one
    task automatic wait_idle(output int n);
        logic [31:0] s;
        n = 0;
        for (int k = 0; k < 64; k++) begin
            reg_read(8'h74, s);
            if (!s[16]) break;
            n++;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [6:0]  addr;
        logic [15:0] data;
        logic [3:0]  lat;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 7'h08, 16'h1234, 4'd1, 16'h0000},
        '{1'b1, 7'h08, 16'h0000, 4'd2, 16'h1234},
        '{1'b0, 7'h4f, 16'hBEEF, 4'd3, 16'h0000},
        '{1'b1, 7'h4f, 16'h0000, 4'd1, 16'hBEEF},
        '{1'b1, 7'h16, 16'h0000, 4'd4, 16'hA516},
        '{1'b1, 7'h00, 16'h0000, 4'd6, 16'hA500}
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w;
        logic [15:0] last_data;
        int n;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(blk_en == 0 && tile_en == 0 && src_sel == 0, "R1 cfg outputs",
              {29'b0, blk_en, tile_en, src_sel}, 0);
        check(drp_en == 0 && drp_we == 0, "R1 drp idle", {30'b0, drp_en, drp_we}, 0);
        reg_read(8'h74, v);
        check(v == 0, "R1 status", v, 0);
        rst_n = 1'b1;

        // R2 reset register
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_read(8'h40, v);
        check(blk_en && tile_en && v == 32'h3, "R2 both set", v, 32'h3);
        reg_write(8'h40, 32'h0000_0001);
        reg_read(8'h40, v);
        check(blk_en && !tile_en && v == 32'h1, "R2 block only", v, 32'h1);

        // R3 source select
        reg_write(8'h44, 32'hFFFF_FFFF);
        reg_read(8'h44, v);
        check(src_sel == 1 && v == 32'h1, "R3 select one", v, 32'h1);
        reg_write(8'h44, 32'hFFFF_FFFE);
        reg_read(8'h44, v);
        check(src_sel == 0 && v == 32'h0, "R3 select zero", v, 32'h0);

        // Vector table: R4, R5, R6, R10
        last_data = 16'h0000;
        foreach (VECS[i]) begin
            resp_lat = int'(VECS[i].lat);
            w = (32'h1 << 29) | (32'(VECS[i].rd) << 28) | (32'(VECS[i].addr) << 16)
                | 32'(VECS[i].data);
            reg_write(8'h70, w);
            check(drp_en == 1'b1, "R4 enable pulse", {31'b0, drp_en}, 1);
            check(drp_we == !VECS[i].rd, "R4 write enable", {31'b0, drp_we},
                  {31'b0, !VECS[i].rd});
            check(drp_addr == VECS[i].addr && drp_di == VECS[i].data, "R4 fields",
                  {9'b0, drp_addr, drp_di}, {9'b0, VECS[i].addr, VECS[i].data});
            @(negedge clk);
            check(drp_en == 1'b0, "R4 pulse ends", {31'b0, drp_en}, 0);
            check(drp_addr == VECS[i].addr && drp_di == VECS[i].data, "R11 fields held",
                  {9'b0, drp_addr, drp_di}, {9'b0, VECS[i].addr, VECS[i].data});
            wait_idle(n);
            check(n == resp_lat + 1, "R5 busy length", n, resp_lat + 1);
            if (VECS[i].rd) last_data = VECS[i].exp;
            reg_read(8'h74, v);
            check(v == {16'h0, last_data}, "R6 status data", v, {16'h0, last_data});
            reg_read(8'h70, v);
            check(v == (w & ~(32'h1 << 29)), "R10 command echo", v, w & ~(32'h1 << 29));
        end

        // R7 command while busy is ignored
        resp_lat = 5;
        reg_write(8'h70, 32'h304F_0000);
        reg_write(8'h70, 32'h2010_5555);
        check(drp_en == 0 && drp_addr == 7'h4f, "R7 busy ignore",
              {24'b0, drp_en, drp_addr}, {24'b0, 1'b0, 7'h4f});
        reg_read(8'h70, v);
        check(v == 32'h104F_0000, "R7 echo while busy", v, 32'h104F_0000);
        wait_idle(n);
        reg_read(8'h74, v);
        check(v == 32'h0000_BEEF, "R7 first access completed", v, 32'h0000_BEEF);
        resp_lat = 1;
        reg_write(8'h70, 32'h3010_0000);
        wait_idle(n);
        reg_read(8'h74, v);
        check(v == 32'h0000_A510, "R7 ignored write left tile", v, 32'h0000_A510);

        // R7 no start bit
        reg_write(8'h70, 32'h1008_0000);
        check(drp_en == 0, "R7 no start", {31'b0, drp_en}, 0);
        reg_read(8'h74, v);
        check(v == 32'h0000_A510, "R7 no start status", v, 32'h0000_A510);
        reg_read(8'h70, v);
        check(v == 32'h1010_0000, "R7 no start echo", v, 32'h1010_0000);

        // R8 stray ready while idle
        @(negedge clk); force_rdy = 1'b1;
        @(negedge clk); force_rdy = 1'b0;
        reg_read(8'h74, v);
        check(v == 32'h0000_A510, "R8 stray ready", v, 32'h0000_A510);

        // R9 unmapped and strobe-low reads
        reg_read(8'h48, v);
        check(v == 0, "R9 unmapped 0x48", v, 0);
        reg_read(8'h00, v);
        check(v == 0, "R9 unmapped 0x00", v, 0);
        reg_addr = 8'h40; #0.5;
        check(reg_rdata == 0, "R9 strobe low", reg_rdata, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule